// File: doc/BRIEF.md
# Cascaded Output Divider with Phase Offset

This block derives a slower clock from a fast input clock through two programmable divide stages in series. Each stage divides by an integer from 1 to 32, so the overall ratio is the product of the two and reaches 1024. A coarse phase offset, counted in fast-clock cycles, delays the start of the divided waveform. Several instances fed by the same fast clock can then be placed at chosen offsets from one another.

All divider state is cleared by a synchronization request. The divided waveform starts again a fixed number of cycles plus the programmed offset after the request is withdrawn. The first clock edge after reset release acts as an automatic synchronization, so every instance released from the same reset starts in phase. The ratios and the offset are sampled only when a synchronization is released. A bypass control forwards the fast clock straight to the outputs. Two output ports carry the same divided clock, as a pair of outputs fed by one divider.

Top module: `casc_clk_div`

## Requirements
- R1: A stage ratio input of 0 is used as 1, a value above 32 is used as 32, and values 1 to 32 are used unchanged.
- R2: While running, the divided clock has a period of N1*N2 fast cycles. If N2 > 1 it is high for ceil(N2/2)*N1 cycles at the start of each period, otherwise for ceil(N1/2) cycles. N1 and N2 are the two effective stage ratios.
- R3: A stage with ratio 1 passes its input through unchanged. When both ratios are 1 the running output equals the fast clock: high while it is high and low while it is low.
- R4: While reset is low the outputs are low (bypass off). The first clock edge with reset high acts as a synchronization release, with no request needed.
- R5: From the first clock edge that samples the sync request high, and for as long as it stays high, the divided output is low.
- R6: The release edge is the first edge that samples sync low after a synchronization. With offset D, the output is low until edge release+1+D and goes high just after that edge.
- R7: An offset input at or above N1*N2 is used as N1*N2-1.
- R8: Ratios and offset are sampled only at the release edge. Later changes to them have no effect until the next synchronization.
- R9: The two output ports always carry the same value.
- R10: While bypass is high, both outputs equal the fast clock. Bypass does not disturb the divider state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sync_i | input | 1 | Synchronization request, active high |
| bypass_i | input | 1 | Forward the fast clock to the outputs |
| ratio_a_i | input | 6 | Ratio of the first stage |
| ratio_b_i | input | 6 | Ratio of the second stage |
| phase_i | input | 10 | Coarse phase offset in fast-clock cycles |
| clk_out_a_o | output | 1 | Divided clock, first of the pair |
| clk_out_b_o | output | 1 | Divided clock, second of the pair |

## Verification
A wrong stage count or level register shows as a high or low phase of the wrong length. The reference model sees that at the first edge where that phase should end, so within one output period. A wrong delay count or release-edge decision moves the first rising edge, and the fault is seen within D+2 cycles of the release. A missing configuration hold shows only after inputs change mid-run, so the bench changes them on purpose and watches the next full period.

// File: rtl/ccd_pkg.sv
// Package: shared constants and the controller state type for the
// cascaded output divider.
package ccd_pkg;
    parameter int DEF_MAX_RATIO = 32;
    parameter int NUM_STAGES    = 2;

    // Controller phases: cleared and waiting for release, counting the
    // phase offset, dividing.
    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } ccd_state_e;
endpackage

// File: rtl/ccd_sync_ctrl.sv
// Module: ccd_sync_ctrl
// Owns the synchronization sequence. It clamps the raw ratios and the
// offset and captures them at the release edge. It then counts the
// offset down and issues the start, advance and clear controls to the
// divide stages.
// Assumes sync_i and the configuration inputs are synchronous to clk_i.
module ccd_sync_ctrl
    import ccd_pkg::*;
#(
    parameter int MAX_RATIO = DEF_MAX_RATIO,
    parameter int RATIO_W   = $clog2(MAX_RATIO + 1),
    parameter int OFS_W     = $clog2(MAX_RATIO * MAX_RATIO),
    parameter int PROD_W    = $clog2(MAX_RATIO * MAX_RATIO + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sync_i,
    input  logic [RATIO_W-1:0] ratio_a_i,
    input  logic [RATIO_W-1:0] ratio_b_i,
    input  logic [OFS_W-1:0]   phase_i,
    output logic [RATIO_W-1:0] n1_o,
    output logic [RATIO_W-1:0] n2_o,
    output logic [OFS_W-1:0]   ofs_o,
    output logic               clear_o,
    output logic               start_o,
    output logic               adv_o,
    output logic               run_o,
    output logic               wait_o
);
    localparam logic [RATIO_W-1:0] RMAX = RATIO_W'(MAX_RATIO);

    ccd_state_e         st_q;
    logic [OFS_W-1:0]   dly_q;
    logic [RATIO_W-1:0] n1_q, n2_q, n1_c, n2_c;
    logic [OFS_W-1:0]   ofs_q, ofs_c;
    logic [PROD_W-1:0]  prod_c;

    // Clamp one raw ratio into 1..MAX_RATIO.
    function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] raw);
        if (raw == '0)
            return RATIO_W'(1);
        else if (raw > RMAX)
            return RMAX;
        else
            return raw;
    endfunction

    // Effective ratios and offset limited to one output period.
    always_comb begin
        n1_c   = clamp_ratio(ratio_a_i);
        n2_c   = clamp_ratio(ratio_b_i);
        prod_c = PROD_W'(n1_c) * PROD_W'(n2_c);
        if (PROD_W'(phase_i) >= prod_c)
            ofs_c = OFS_W'(prod_c - PROD_W'(1));
        else
            ofs_c = phase_i;
    end

    // Sequence state, offset countdown and configuration capture.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q  <= ST_HOLD;
            dly_q <= '0;
            n1_q  <= RATIO_W'(1);
            n2_q  <= RATIO_W'(1);
            ofs_q <= '0;
        end else if (sync_i) begin
            st_q  <= ST_HOLD;
            dly_q <= '0;
        end else begin
            unique case (st_q)
                ST_HOLD: begin
                    n1_q  <= n1_c;
                    n2_q  <= n2_c;
                    ofs_q <= ofs_c;
                    dly_q <= ofs_c;
                    st_q  <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (dly_q == '0)
                        st_q <= ST_RUN;
                    else
                        dly_q <= dly_q - OFS_W'(1);
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end

    // Stage controls derived from the current phase.
    always_comb begin
        clear_o = sync_i;
        start_o = !sync_i && (st_q == ST_WAIT) && (dly_q == '0);
        adv_o   = !sync_i && (st_q == ST_RUN);
        run_o   = (st_q == ST_RUN);
        wait_o  = (st_q == ST_WAIT);
    end

    assign n1_o  = n1_q;
    assign n2_o  = n2_q;
    assign ofs_o = ofs_q;
endmodule

// File: rtl/ccd_div_stage.sv
// Module: ccd_div_stage
// One programmable divide stage. It counts enable events modulo its
// ratio and keeps a registered level that is high for the first
// ceil(ratio/2) positions. It flags the event that wraps the count.
// A ratio of 1 keeps the level high and wraps on every event.
// Assumes ratio_i is already clamped to 1..MAX_RATIO and held stable.
module ccd_div_stage #(
    parameter int RATIO_W = 6
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               clear_i,
    input  logic               start_i,
    input  logic               en_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               lvl_o,
    output logic               wrap_o
);
    logic [RATIO_W-1:0] cnt_q, cnt_nxt, half;
    logic               last, lvl_q;

    // Wrap point, next position and the high-phase length.
    always_comb begin
        last    = (cnt_q == ratio_i - RATIO_W'(1));
        cnt_nxt = last ? '0 : cnt_q + RATIO_W'(1);
        half    = (ratio_i + RATIO_W'(1)) >> 1;
        wrap_o  = en_i && last;
    end

    // Position counter and level register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni || clear_i) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
        end else if (start_i) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (en_i) begin
            cnt_q <= cnt_nxt;
            lvl_q <= (cnt_nxt < half);
        end
    end

    assign lvl_o = lvl_q;
endmodule

// File: rtl/ccd_out_sel.sv
// Module: ccd_out_sel
// Picks the divided clock from the stage levels. Stage two is used when
// it divides. Stage one is used when only it divides. When both ratios
// are 1 the fast clock is gated by the running level. Bypass forwards
// the fast clock.
// Assumes the levels are low whenever the divider is not running.
module ccd_out_sel #(
    parameter int RATIO_W = 6
) (
    input  logic               clk_i,
    input  logic               bypass_i,
    input  logic               lvl1_i,
    input  logic               lvl2_i,
    input  logic [RATIO_W-1:0] n1_i,
    input  logic [RATIO_W-1:0] n2_i,
    output logic               div_o,
    output logic               out_o
);
    // Source selection for the divided and forwarded clock.
    always_comb begin
        if (n2_i != RATIO_W'(1))
            div_o = lvl2_i;
        else if (n1_i != RATIO_W'(1))
            div_o = lvl1_i;
        else
            div_o = lvl1_i & clk_i;
        out_o = bypass_i ? clk_i : div_o;
    end
endmodule

// File: rtl/casc_clk_div.sv
// Module: casc_clk_div (top)
// Two cascaded programmable divide stages with a coarse phase offset and
// synchronization. Stage one advances on every running fast cycle, and
// each later stage advances when the stage before it wraps. Both output
// ports carry the same divided clock.
// Assumes a single clock domain. Ratio and offset inputs are sampled at
// the release edge only.
module casc_clk_div
    import ccd_pkg::*;
#(
    parameter int MAX_RATIO = DEF_MAX_RATIO,
    localparam int RATIO_W  = $clog2(MAX_RATIO + 1),
    localparam int OFS_W    = $clog2(MAX_RATIO * MAX_RATIO)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sync_i,
    input  logic               bypass_i,
    input  logic [RATIO_W-1:0] ratio_a_i,
    input  logic [RATIO_W-1:0] ratio_b_i,
    input  logic [OFS_W-1:0]   phase_i,
    output logic               clk_out_a_o,
    output logic               clk_out_b_o
);
    logic [RATIO_W-1:0]    cfg_n1, cfg_n2;
    logic [OFS_W-1:0]      cfg_ofs;
    logic                  clear, start, adv, run, waiting;
    logic [NUM_STAGES-1:0] lvl, wrap, en;
    logic [RATIO_W-1:0]    ratio [NUM_STAGES];
    logic                  div_out, out;

    ccd_sync_ctrl #(.MAX_RATIO(MAX_RATIO)) u_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sync_i    (sync_i),
        .ratio_a_i (ratio_a_i),
        .ratio_b_i (ratio_b_i),
        .phase_i   (phase_i),
        .n1_o      (cfg_n1),
        .n2_o      (cfg_n2),
        .ofs_o     (cfg_ofs),
        .clear_o   (clear),
        .start_o   (start),
        .adv_o     (adv),
        .run_o     (run),
        .wait_o    (waiting)
    );

    assign ratio[0] = cfg_n1;
    assign ratio[1] = cfg_n2;

    // Stage chain: each stage advances on the wrap of the one before it.
    for (genvar gi = 0; gi < NUM_STAGES; gi++) begin : g_stage
        if (gi == 0) begin : g_first
            assign en[gi] = adv;
        end else begin : g_next
            assign en[gi] = wrap[gi-1];
        end
        ccd_div_stage #(.RATIO_W(RATIO_W)) u_stage (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .clear_i (clear),
            .start_i (start),
            .en_i    (en[gi]),
            .ratio_i (ratio[gi]),
            .lvl_o   (lvl[gi]),
            .wrap_o  (wrap[gi])
        );
    end

    ccd_out_sel #(.RATIO_W(RATIO_W)) u_sel (
        .clk_i    (clk_i),
        .bypass_i (bypass_i),
        .lvl1_i   (lvl[0]),
        .lvl2_i   (lvl[1]),
        .n1_i     (cfg_n1),
        .n2_i     (cfg_n2),
        .div_o    (div_out),
        .out_o    (out)
    );

    assign clk_out_a_o = out;
    assign clk_out_b_o = out;
endmodule

// File: rtl/ccd_checker.sv
// Module: ccd_checker
// Properties of the cascaded divider, attached to the top by bind.
// Assumes the captured configuration, the phase flags and the unbypassed
// divided clock of the top are visible.
module ccd_checker #(
    parameter int MAX_RATIO = 32,
    parameter int RATIO_W   = 6,
    parameter int OFS_W     = 10
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               sync_i,
    input logic               run,
    input logic               waiting,
    input logic               div_out,
    input logic [RATIO_W-1:0] cfg_n1,
    input logic [RATIO_W-1:0] cfg_n2,
    input logic [OFS_W-1:0]   cfg_ofs
);
    // R5: a sampled sync request silences the divided clock next cycle.
    a_r5_sync_silences: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_i |=> !div_out);

    // R6: no output while the offset is still being counted.
    a_r6_wait_is_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        waiting |-> !div_out);

    // R1: captured ratios stay in the legal range once dividing.
    a_r1_ratio_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run |-> (cfg_n1 >= 1 && cfg_n1 <= MAX_RATIO && cfg_n2 >= 1 && cfg_n2 <= MAX_RATIO));

    // R7: captured offset lies within one output period.
    a_r7_offset_in_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run || waiting) |-> (32'(cfg_ofs) < 32'(cfg_n1) * 32'(cfg_n2)));

    // R8: configuration does not move while dividing without a request.
    a_r8_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run && !sync_i) |=> ($stable(cfg_n1) && $stable(cfg_n2) && $stable(cfg_ofs)));
endmodule

bind casc_clk_div ccd_checker #(
    .MAX_RATIO (MAX_RATIO),
    .RATIO_W   (RATIO_W),
    .OFS_W     (OFS_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .run     (run),
    .waiting (waiting),
    .div_out (div_out),
    .cfg_n1  (cfg_n1),
    .cfg_n2  (cfg_n2),
    .cfg_ofs (cfg_ofs)
);

// File: tb/casc_clk_div_tb.sv
// Bench: behavioural reference of the divided clock, compared every cycle.
module casc_clk_div_tb;
    localparam int MAXR = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync = 1'b0;
    logic       byp = 1'b0;
    logic [5:0] ra = 6'd3;
    logic [5:0] rb = 6'd1;
    logic [9:0] ph = 10'd0;
    logic       out_a, out_b;

    int    checks = 0;
    int    fails  = 0;
    string req    = "R4";
    bit    done   = 1'b0;

    // Reference state: 0 hold, 1 counting offset, 2 dividing.
    int m_st = 0, m_dly = 0, m_k = 0, m_n1 = 1, m_n2 = 1;

    always #10 clk = ~clk;

    casc_clk_div u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .sync_i      (sync),
        .bypass_i    (byp),
        .ratio_a_i   (ra),
        .ratio_b_i   (rb),
        .phase_i     (ph),
        .clk_out_a_o (out_a),
        .clk_out_b_o (out_b)
    );

    function automatic int clampr(int v);
        if (v == 0) return 1;
        if (v > MAXR) return MAXR;
        return v;
    endfunction

    function automatic bit model_out();
        int p;
        if (byp) return 1'b1;
        if (m_st != 2) return 1'b0;
        if (m_n2 > 1) begin
            p = (m_k / m_n1) % m_n2;
            return p < (m_n2 + 1) / 2;
        end
        if (m_n1 > 1) return (m_k % m_n1) < (m_n1 + 1) / 2;
        return 1'b1;
    endfunction

    task automatic check(string r, bit act, bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%b expected=%b", r, $time, act, exp);
        end
    endtask

    // Reference update at each edge, then compare while the clock is high.
    always @(posedge clk) begin
        if (!rst_n || sync) begin
            m_st = 0;
        end else begin
            case (m_st)
                0: begin
                    m_n1 = clampr(int'(ra));
                    m_n2 = clampr(int'(rb));
                    m_dly = (int'(ph) >= m_n1 * m_n2) ? m_n1 * m_n2 - 1 : int'(ph);
                    m_st = 1;
                end
                1: begin
                    if (m_dly == 0) begin m_st = 2; m_k = 0; end
                    else m_dly--;
                end
                default: m_k = (m_k + 1) % (m_n1 * m_n2);
            endcase
        end
        #5;
        if (!done) begin
            check(req, out_a, model_out());
            check("R9", out_b, out_a);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic resync(int a, int b, int o, int hold);
        @(negedge clk);
        ra = 6'(a); rb = 6'(b); ph = 10'(o); sync = 1'b1;
        cyc(hold);
        sync = 1'b0;
    endtask

    initial begin
        // R4: reset holds outputs low, then the automatic release runs.
        cyc(5);
        #1 check("R4", out_a, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        cyc(30);
        req = "R2"; resync(4, 3, 0, 1); cyc(60);
        req = "R2"; resync(5, 1, 0, 1); cyc(40);
        req = "R3"; resync(1, 7, 0, 1); cyc(40);
        req = "R6"; resync(3, 5, 7, 1); cyc(70);
        req = "R6"; resync(6, 2, 11, 2); cyc(40);
        // R3: both ratios 1 follow the fast clock; low while it is low.
        req = "R3"; resync(1, 1, 0, 1); cyc(10);
        #1 check("R3", out_a, 1'b0);
        req = "R1"; resync(0, 40, 5, 1); cyc(100);
        req = "R1"; resync(63, 2, 0, 1); cyc(140);
        req = "R7"; resync(2, 2, 100, 1); cyc(30);
        // R8: inputs changed mid-run are ignored.
        req = "R8"; resync(4, 2, 1, 1); cyc(20);
        ra = 6'd7; rb = 6'd5; ph = 10'd3; cyc(60);
        // R5: a long request keeps the output low.
        req = "R5"; resync(2, 3, 0, 6); cyc(30);
        // R10: bypass forwards the fast clock and leaves the divider alone.
        req = "R10"; byp = 1'b1; cyc(4);
        #1 check("R10", out_a, 1'b0);
        @(negedge clk); byp = 1'b0;
        req = "R10"; cyc(30);
        req = "R2"; resync(32, 32, 1023, 1); cyc(2200);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        done = 1'b1;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule